// File: doc/BRIEF.md
# Interprocessor Interrupt Target Resolver

This block takes one interprocessor interrupt command and works out which local interrupt controllers receive it. The command arrives as separate fields: destination ID, destination mode (physical or logical), delivery mode, shorthand, level and trigger bits, and vector. It comes with the sender's own ID and, for every controller slot, a present flag, an 8-bit logical ID and a 4-bit model code. One clock after the command strobe, the block drives a per-slot target mask and exactly one of four strobes: ordinary interrupt, INIT, arbitration-ID resync, or start-up. The vector and the delivery mode go out with the strobe.

The shorthand picks the target set. It can be the destination field, the sender alone, everyone, or everyone except the sender. A destination field is read as a slot number in physical mode. In logical mode each slot's ID is matched against it in flat or cluster fashion. Slots that are not present are dropped. In lowest-priority mode the set shrinks to the lowest-numbered remaining slot. An INIT command with level low and trigger high does not reset anyone; it only tells the targets to reload their arbitration IDs. A start-up command only forwards its vector; what a halted processor does with it lies outside this block.

Top module: `ipi_target_resolver`

## Requirements
- R1: While reset is high, and on the first cycle after it, all four strobes are low and the target mask is zero.
- R2: A command sampled on a rising edge with cmd_valid high produces its result on the outputs directly after that edge. At most one strobe is high at a time, and strobes are high only in the cycle after a command.
- R3: The shorthand code selects the target set: 0 uses the destination field, 1 selects the slot equal to self_id, 2 selects all slots, and 3 selects all slots except self_id.
- R4: With shorthand 0 and physical mode (cmd_logical = 0), destination 0xFF selects every slot. Any other value selects only the slot whose index equals it.
- R5: With shorthand 0 and logical mode, a slot with model code 0xF (flat) matches when destination AND its logical ID is nonzero.
- R6: With shorthand 0 and logical mode, a slot with model code 0x0 (cluster) matches only when the upper nibbles of destination and logical ID are equal and their lower nibbles share a set bit. A slot with any other model code never matches.
- R7: Slots whose present bit is 0 are cleared from the mask. When the resulting mask is empty, no strobe is raised and the mask output stays zero.
- R8: Delivery mode code 1 (lowest priority) reduces the mask to the single set bit with the lowest index and raises the interrupt strobe.
- R9: Delivery mode code 5 (INIT) raises the arbitration-resync strobe when cmd_level = 0 and cmd_trig = 1. Otherwise it raises the INIT strobe. In both cases the full mask is driven.
- R10: Delivery mode code 6 (start-up) raises the start strobe with the full mask, and out_vector equals the command's vector.
- R11: Delivery mode codes 0, 2, 3, 4 and 7 raise the interrupt strobe with the full mask. out_vector and out_mode carry the command's vector and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command launch strobe |
| cmd_vector | input | 8 | Interrupt vector |
| cmd_dmode | input | 3 | Delivery mode code |
| cmd_logical | input | 1 | 1 = logical destination, 0 = physical |
| cmd_level | input | 1 | Level bit |
| cmd_trig | input | 1 | Trigger bit |
| cmd_shorthand | input | 2 | Destination shorthand code |
| cmd_dest | input | 8 | Destination field |
| self_id | input | 8 | ID of the sending controller |
| slot_present | input | NUM_SLOTS | Slot-present flags |
| slot_logid | input | NUM_SLOTS*8 | Logical ID per slot, slot i at bits [8i+7:8i] |
| slot_model | input | NUM_SLOTS*4 | Model code per slot, slot i at bits [4i+3:4i] |
| out_irq | output | 1 | Interrupt delivery strobe |
| out_init | output | 1 | INIT delivery strobe |
| out_arb_sync | output | 1 | Arbitration-ID resync strobe |
| out_start | output | 1 | Start-up strobe |
| out_mask | output | NUM_SLOTS | Resolved target mask |
| out_vector | output | 8 | Vector of the delivered command |
| out_mode | output | 3 | Delivery mode of the delivered command |

## Verification
The bench runs on eight slots and sweeps every destination value against all four shorthands and both destination modes. It uses two slot setups. The first mixes flat, cluster and non-matching model codes and leaves one slot absent. The second is all-cluster with shared upper nibbles, which separates nibble equality from plain overlap. The sender ID is moved across slots, including an absent one and one beyond the slot count, so self-only and all-but-self sets come out empty, single or full. The delivery mode, level and trigger bits cycle with the destination, so lowest-priority reduction, INIT versus resync and start-up forwarding are each seen on many different masks, including empty ones.

// File: rtl/ipi_res_pkg.sv
package ipi_res_pkg;

    localparam int ID_W    = 8;
    localparam int VEC_W   = 8;
    localparam int MODEL_W = 4;

    localparam logic [ID_W-1:0]    BCAST_ID      = 8'hFF;
    localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
    localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [2:0] {
        DM_FIXED  = 3'd0,
        DM_LOWEST = 3'd1,
        DM_SMI    = 3'd2,
        DM_RSVD   = 3'd3,
        DM_NMI    = 3'd4,
        DM_INIT   = 3'd5,
        DM_START  = 3'd6,
        DM_EXTINT = 3'd7
    } dmode_e;

    typedef enum logic [1:0] {
        SH_FIELD  = 2'd0,
        SH_SELF   = 2'd1,
        SH_ALL    = 2'd2,
        SH_OTHERS = 2'd3
    } short_e;

    typedef enum logic [1:0] {
        K_IRQ   = 2'd0,
        K_INIT  = 2'd1,
        K_ARB   = 2'd2,
        K_START = 2'd3
    } kind_e;

    typedef struct packed {
        logic [VEC_W-1:0] vector;
        dmode_e           dmode;
        logic             logical;
        logic             level;
        logic             trig;
        short_e           shorthand;
        logic [ID_W-1:0]  dest;
    } ipi_cmd_t;

    // Logical match of one slot against the destination field.
    function automatic logic logical_hit(input logic [ID_W-1:0] dest,
                                         input logic [ID_W-1:0] lid,
                                         input logic [MODEL_W-1:0] model);
        logic hit;
        if (model == MODEL_FLAT)
            hit = |(dest & lid);
        else if (model == MODEL_CLUSTER)
            hit = (dest[7:4] == lid[7:4]) && (|(dest[3:0] & lid[3:0]));
        else
            hit = 1'b0;
        return hit;
    endfunction

    // Which output strobe a command belongs to.
    function automatic kind_e classify(input ipi_cmd_t c);
        kind_e k;
        case (c.dmode)
            DM_INIT:  k = (!c.level && c.trig) ? K_ARB : K_INIT;
            DM_START: k = K_START;
            default:  k = K_IRQ;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/ipi_dest_decode.sv
module ipi_dest_decode
    import ipi_res_pkg::*;
#(
    parameter int NUM_SLOTS = 256
) (
    input  ipi_cmd_t                      cmd,
    input  logic [ID_W-1:0]               self_id,
    input  logic [NUM_SLOTS-1:0]          slot_present,
    input  logic [NUM_SLOTS*ID_W-1:0]     slot_logid,
    input  logic [NUM_SLOTS*MODEL_W-1:0]  slot_model,
    output logic [NUM_SLOTS-1:0]          raw_mask
);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic phys_hit;
        logic log_hit;
        logic is_self;
        logic sel;

        assign phys_hit = (cmd.dest == BCAST_ID) || (cmd.dest == ID_W'(i));
        assign log_hit  = logical_hit(cmd.dest,
                                      slot_logid[i*ID_W +: ID_W],
                                      slot_model[i*MODEL_W +: MODEL_W]);
        assign is_self  = (self_id == ID_W'(i));

        always_comb begin
            case (cmd.shorthand)
                SH_FIELD:  sel = cmd.logical ? log_hit : phys_hit;
                SH_SELF:   sel = is_self;
                SH_ALL:    sel = 1'b1;
                default:   sel = !is_self;
            endcase
        end

        assign raw_mask[i] = sel & slot_present[i];
    end

endmodule

// File: rtl/ipi_pick_lowest.sv
module ipi_pick_lowest #(
    parameter int NUM_SLOTS = 256
) (
    input  logic [NUM_SLOTS-1:0] mask_in,
    output logic [NUM_SLOTS-1:0] mask_out
);

    // Two's-complement isolation of the least significant set bit.
    assign mask_out = mask_in & (~mask_in + NUM_SLOTS'(1));

endmodule

// File: rtl/ipi_target_resolver.sv
module ipi_target_resolver
    import ipi_res_pkg::*;
#(
    parameter int NUM_SLOTS = 256
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cmd_valid,
    input  logic [7:0]                    cmd_vector,
    input  logic [2:0]                    cmd_dmode,
    input  logic                          cmd_logical,
    input  logic                          cmd_level,
    input  logic                          cmd_trig,
    input  logic [1:0]                    cmd_shorthand,
    input  logic [7:0]                    cmd_dest,
    input  logic [7:0]                    self_id,
    input  logic [NUM_SLOTS-1:0]          slot_present,
    input  logic [NUM_SLOTS*8-1:0]        slot_logid,
    input  logic [NUM_SLOTS*4-1:0]        slot_model,
    output logic                          out_irq,
    output logic                          out_init,
    output logic                          out_arb_sync,
    output logic                          out_start,
    output logic [NUM_SLOTS-1:0]          out_mask,
    output logic [7:0]                    out_vector,
    output logic [2:0]                    out_mode
);

    ipi_cmd_t             cmd;
    kind_e                kind;
    logic [NUM_SLOTS-1:0] raw_mask;
    logic [NUM_SLOTS-1:0] low_mask;
    logic [NUM_SLOTS-1:0] final_mask;
    logic                 launch;

    always_comb begin
        cmd.vector    = cmd_vector;
        cmd.dmode     = dmode_e'(cmd_dmode);
        cmd.logical   = cmd_logical;
        cmd.level     = cmd_level;
        cmd.trig      = cmd_trig;
        cmd.shorthand = short_e'(cmd_shorthand);
        cmd.dest      = cmd_dest;
    end

    ipi_dest_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
        .cmd          (cmd),
        .self_id      (self_id),
        .slot_present (slot_present),
        .slot_logid   (slot_logid),
        .slot_model   (slot_model),
        .raw_mask     (raw_mask)
    );

    ipi_pick_lowest #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .mask_in  (raw_mask),
        .mask_out (low_mask)
    );

    assign kind       = classify(cmd);
    assign final_mask = (cmd.dmode == DM_LOWEST) ? low_mask : raw_mask;
    assign launch     = cmd_valid && (|raw_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_irq      <= 1'b0;
            out_init     <= 1'b0;
            out_arb_sync <= 1'b0;
            out_start    <= 1'b0;
            out_mask     <= '0;
            out_vector   <= '0;
            out_mode     <= '0;
        end else begin
            out_irq      <= launch && (kind == K_IRQ);
            out_init     <= launch && (kind == K_INIT);
            out_arb_sync <= launch && (kind == K_ARB);
            out_start    <= launch && (kind == K_START);
            out_mask     <= launch ? final_mask : '0;
            if (cmd_valid) begin
                out_vector <= cmd.vector;
                out_mode   <= cmd.dmode;
            end
        end
    end

endmodule

// File: rtl/ipi_target_resolver_chk.sv
module ipi_target_resolver_chk #(
    parameter int NUM_SLOTS = 256
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [7:0]           cmd_vector,
    input logic [2:0]           cmd_dmode,
    input logic [NUM_SLOTS-1:0] slot_present,
    input logic                 out_irq,
    input logic                 out_init,
    input logic                 out_arb_sync,
    input logic                 out_start,
    input logic [NUM_SLOTS-1:0] out_mask,
    input logic [7:0]           out_vector,
    input logic [2:0]           out_mode
);

    logic any_strobe;
    assign any_strobe = out_irq | out_init | out_arb_sync | out_start;

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (!any_strobe && out_mask == '0));

    // R2
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_irq, out_init, out_arb_sync, out_start}));

    // R2
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !any_strobe);

    // R7
    a_r7_only_present: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> ((out_mask & ~$past(slot_present)) == '0));

    // R7
    a_r7_strobe_needs_target: assert property (@(posedge clk) disable iff (rst)
        any_strobe |-> (out_mask != '0));

    // R8
    a_r8_lowest_single: assert property (@(posedge clk) disable iff (rst)
        (out_irq && out_mode == 3'd1) |-> ($countones(out_mask) == 1));

    // R9
    a_r9_init_kinds_only: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_dmode != 3'd5) |=> (!out_init && !out_arb_sync));

    // R10
    a_r10_start_vector: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> (!out_start || out_vector == $past(cmd_vector)));

endmodule

bind ipi_target_resolver ipi_target_resolver_chk #(.NUM_SLOTS(NUM_SLOTS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_vector   (cmd_vector),
    .cmd_dmode    (cmd_dmode),
    .slot_present (slot_present),
    .out_irq      (out_irq),
    .out_init     (out_init),
    .out_arb_sync (out_arb_sync),
    .out_start    (out_start),
    .out_mask     (out_mask),
    .out_vector   (out_vector),
    .out_mode     (out_mode)
);

// File: tb/ipi_target_resolver_test.sv
module ipi_target_resolver_test;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cmd_valid = 1'b0;
    logic [7:0]   cmd_vector = '0;
    logic [2:0]   cmd_dmode = '0;
    logic         cmd_logical = 1'b0;
    logic         cmd_level = 1'b0;
    logic         cmd_trig = 1'b0;
    logic [1:0]   cmd_shorthand = '0;
    logic [7:0]   cmd_dest = '0;
    logic [7:0]   self_id = '0;
    logic [N-1:0] slot_present = '0;
    logic [N*8-1:0] slot_logid = '0;
    logic [N*4-1:0] slot_model = '0;
    logic         out_irq, out_init, out_arb_sync, out_start;
    logic [N-1:0] out_mask;
    logic [7:0]   out_vector;
    logic [2:0]   out_mode;

    logic [7:0] lid [N];
    logic [3:0] mdl [N];
    int         cfg_sel;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ipi_target_resolver #(.NUM_SLOTS(N)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_vector(cmd_vector),
        .cmd_dmode(cmd_dmode), .cmd_logical(cmd_logical), .cmd_level(cmd_level),
        .cmd_trig(cmd_trig), .cmd_shorthand(cmd_shorthand), .cmd_dest(cmd_dest),
        .self_id(self_id), .slot_present(slot_present), .slot_logid(slot_logid),
        .slot_model(slot_model), .out_irq(out_irq), .out_init(out_init),
        .out_arb_sync(out_arb_sync), .out_start(out_start), .out_mask(out_mask),
        .out_vector(out_vector), .out_mode(out_mode)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_cfg(input int c);
        for (int i = 0; i < N; i++) begin
            if (c == 0) begin
                if (i < 4) begin
                    mdl[i] = 4'hF;
                    lid[i] = 8'(1 << i) | ((i == 3) ? 8'h80 : 8'h00);
                end else if (i < 7) begin
                    mdl[i] = 4'h0;
                    lid[i] = {4'h2, 4'(1 << (i - 4))};
                end else begin
                    mdl[i] = 4'h5;
                    lid[i] = 8'hFF;
                end
            end else begin
                mdl[i] = 4'h0;
                lid[i] = {4'(i / 2), 4'(4'b0011 << (i % 2))};
            end
            slot_logid[i*8 +: 8] = lid[i];
            slot_model[i*4 +: 4] = mdl[i];
        end
        slot_present = (c == 0) ? 8'hBF : 8'hFF;
        cfg_sel = c;
    endtask

    // Expected target set per requirements R3..R7.
    function automatic logic [N-1:0] ref_mask(input int sh, input logic lg, input logic [7:0] d,
                                             input logic [7:0] me);
        logic [N-1:0] m;
        for (int i = 0; i < N; i++) begin
            logic hit;
            case (sh)
                0: begin
                    if (!lg) hit = (d == 8'hFF) || (int'(d) == i);
                    else if (mdl[i] == 4'hF) hit = (d & lid[i]) != 0;
                    else if (mdl[i] == 4'h0)
                        hit = (d[7:4] == lid[i][7:4]) && ((d[3:0] & lid[i][3:0]) != 0);
                    else hit = 1'b0;
                end
                1: hit = (int'(me) == i);
                2: hit = 1'b1;
                default: hit = (int'(me) != i);
            endcase
            m[i] = hit && slot_present[i];
        end
        return m;
    endfunction

    // Issues one command at a falling edge and checks the result one edge later.
    task automatic issue(input int sh, input logic lg, input logic [7:0] d, input logic [2:0] dm,
                         input logic lv, input logic tg, input logic [7:0] vec);
        logic [N-1:0] full, exp_mask;
        logic [3:0]   exp_strb;
        string        mtag, stag;
        full = ref_mask(sh, lg, d, self_id);
        cmd_valid = 1'b1; cmd_shorthand = 2'(sh); cmd_logical = lg; cmd_dest = d;
        cmd_dmode = dm; cmd_level = lv; cmd_trig = tg; cmd_vector = vec;
        exp_mask = full;
        if (dm == 3'd1) begin
            exp_mask = '0;
            for (int i = N - 1; i >= 0; i--) if (full[i]) exp_mask = N'(1) << i;
        end
        if (full == '0)                exp_strb = 4'b0000;
        else if (dm == 3'd5)           exp_strb = (!lv && tg) ? 4'b0010 : 4'b0100;
        else if (dm == 3'd6)           exp_strb = 4'b0001;
        else                           exp_strb = 4'b1000;
        if (sh != 0)         mtag = "R3 shorthand mask";
        else if (!lg)        mtag = "R4 physical mask";
        else if (cfg_sel==1) mtag = "R6 cluster mask";
        else                 mtag = "R5 flat/cluster mask";
        if (full == '0)      stag = "R7 empty set strobes";
        else if (dm == 3'd1) stag = "R8 lowest priority strobe";
        else if (dm == 3'd5) stag = "R9 init strobe kind";
        else if (dm == 3'd6) stag = "R10 start strobe";
        else                 stag = "R11 interrupt strobe";
        @(negedge clk);
        cmd_valid = 1'b0;
        check(mtag, 32'(out_mask), 32'(exp_mask));
        check(stag, {28'd0, out_irq, out_init, out_arb_sync, out_start}, {28'd0, exp_strb});
        if (exp_strb != 4'b0000)
            check((dm == 3'd6) ? "R10 vector" : "R11 vector and mode",
                  {21'd0, out_mode, out_vector}, {21'd0, dm, vec});
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        int selves [4] = '{0, 5, 6, 9};
        load_cfg(0);
        repeat (2) @(negedge clk);
        // R1: during reset
        check("R1 reset strobes", {28'd0, out_irq, out_init, out_arb_sync, out_start}, 32'd0);
        check("R1 reset mask", 32'(out_mask), 32'd0);
        cmd_valid = 1'b1; cmd_shorthand = 2'd2;
        @(negedge clk);
        rst = 1'b0; cmd_valid = 1'b0;
        @(negedge clk);
        check("R1 first cycle after reset", {28'd0, out_irq, out_init, out_arb_sync, out_start}, 32'd0);

        for (int c = 0; c < 2; c++) begin
            load_cfg(c);
            for (int s = 0; s < 4; s++) begin
                self_id = 8'(selves[s]);
                for (int lg = 0; lg < 2; lg++) begin
                    for (int d = 0; d < 256; d++) begin
                        for (int sh = 0; sh < 4; sh++) begin
                            logic [7:0] dv;
                            dv = 8'(d);
                            issue(sh, 1'(lg), dv, dv[2:0] ^ 3'(sh), dv[3], dv[4], dv ^ 8'(sh * 37));
                        end
                    end
                    // R2: idle cycle gives no strobe
                    @(negedge clk);
                    check("R2 idle no strobe", {28'd0, out_irq, out_init, out_arb_sync, out_start}, 32'd0);
                    check("R2 idle mask", 32'(out_mask), 32'd0);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule